// File: doc/BRIEF.md
# Microsecond Interval Timer Bank

A bank of periodic interval timers driven by a shared one-microsecond tick enable. One system timer raises the level-10 tick interrupt. Each of up to `NUM_CPU` per-processor timers raises that processor's level-14 profiling interrupt. All timers work the same way. Each holds a limit and a running count. Both are kept in a field that starts at bit 10 of a 32-bit register word. Software programs the limit as the period in microseconds plus one, shifted up by 10.

On each tick a timer with a nonzero limit steps its count. When the stepped value reaches the limit, the count returns to 1 and the timer's pending flag is set. That gives one interrupt every limit minus one ticks. The pending flag drives the timer's interrupt output and stays up until software reads that timer's limit register. That read returns the flag in bit 31 and acknowledges the interrupt. A limit of zero parks the timer.

Each per-processor timer has its own page of the address space, at page number equal to its index. The system timer sits on the page after the last processor. Reads return data one cycle after the request.

Top module: `usec_timer_bank`

## Requirements
- R1: After reset every limit is 0, every count is 1, every pending flag and interrupt output is low, and `bus_rdata` is 0.
- R2: A write to a timer's limit register (word offset 0 of its page) loads bits 30:10 of the data as the limit, ignores bits 31 and 9:0, returns the count to 1 and clears the pending flag. A later limit read returns the limit in bits 30:10 and zeros in bits 9:0.
- R3: On a cycle with `us_tick` high and a nonzero limit, the count becomes count+1. If count+1 is greater than or equal to the limit, the count becomes 1 and the pending flag is set instead. After a limit write of L >= 2 and k ticks, the count is 1 + (k mod (L-1)) and the flag is set once k >= L-1. A limit of 1 sets the flag on every tick.
- R4: Without a tick, counts and limits hold their values across any number of cycles.
- R5: While a timer's limit is 0, its count stays 1 and its pending flag stays clear regardless of ticks.
- R6: A read of a timer's limit register returns the pending flag in bit 31 and clears the flag after the read. If a wrap occurs in the same cycle, the read returns the old flag and the flag ends set.
- R7: The count register (byte offset 4 of the page) reads as {pending, count in bits 30:10, zero in bits 9:0}. Reading it has no side effect. Writes to it are ignored.
- R8: Timer j (j < NUM_CPU) decodes at `bus_addr[ADDR_W-1:PAGE_AW] == j` and the system timer at page `NUM_CPU`. Pages above that, offsets other than 0 and 4, and addresses with bits 1:0 nonzero are unmapped. Unmapped reads return 0 and unmapped writes change nothing.
- R9: `irq_sys_l10` follows the system timer's pending flag and `irq_cpu_l14[j]` follows timer j's flag. Timers count and acknowledge independently.
- R10: `bus_rdata` is registered. It carries the read word in the cycle after a read request and is 0 in the cycle after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle enable every microsecond |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address, page number above bit PAGE_AW |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq_sys_l10 | output | 1 | System timer interrupt (level 10) |
| irq_cpu_l14 | output | NUM_CPU | Per-processor profiling interrupts (level 14) |

## Verification
The bench sweeps every timer through several small limits. After every tick it compares the count against the closed form 1 + (k mod (L-1)), which exposes an off-by-one period or a count that restarts at 0. It races a wrap against a limit read in the same cycle. A design that gives the acknowledge priority would drop that interrupt and leave the output low. It also checks that a zero limit stays silent, that a limit of 1 fires every tick, that count reads and count writes leave the flag and count alone, and that unmapped, misaligned or out-of-range pages neither answer nor disturb any timer.

// File: rtl/utmr_pkg.sv
package utmr_pkg;
  localparam int WORD_W    = 32;
  localparam int FLD_LSB   = 10;
  localparam int FLD_MAX_W = WORD_W - FLD_LSB - 1;

  typedef logic [FLD_MAX_W-1:0] fld_t;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_LIMIT = 2'd1,
    RK_COUNT = 2'd2
  } reg_kind_e;

  typedef struct packed {
    fld_t cnt;
    logic wrap;
  } step_t;

  // Extract the microsecond field from a register word.
  function automatic fld_t word_to_field(input logic [WORD_W-1:0] w);
    return w[WORD_W-2:FLD_LSB];
  endfunction

  // Build a register word: flag on top, field above bit 10, zeros below.
  function automatic logic [WORD_W-1:0] field_to_word(input logic flag, input fld_t f);
    return {flag, f, {FLD_LSB{1'b0}}};
  endfunction

  // One tick of a timer: step the count, wrap to 1 when reaching the limit.
  function automatic step_t tick_step(input fld_t cnt, input fld_t lim);
    logic [FLD_MAX_W:0] nxt;
    step_t s;
    nxt    = {1'b0, cnt} + (FLD_MAX_W+1)'(1);
    s.cnt  = cnt;
    s.wrap = 1'b0;
    if (lim != '0) begin
      if (nxt >= {1'b0, lim}) begin
        s.cnt  = fld_t'(1);
        s.wrap = 1'b1;
      end else begin
        s.cnt = nxt[FLD_MAX_W-1:0];
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/utmr_core.sv
module utmr_core
  import utmr_pkg::*;
#(
  parameter int FIELD_W = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               lim_wr_i,
  input  logic [FIELD_W-1:0] lim_wdata_i,
  input  logic               lim_rd_i,
  output logic [FIELD_W-1:0] cnt_o,
  output logic [FIELD_W-1:0] lim_o,
  output logic               pend_o,
  output logic               wrap_o
);
  logic [FIELD_W-1:0] cnt_q;
  logic [FIELD_W-1:0] lim_q;
  logic               pend_q;
  step_t              step;

  always_comb step = tick_step(fld_t'(cnt_q), fld_t'(lim_q));

  assign wrap_o = tick_i & step.wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q  <= '0;
      cnt_q  <= FIELD_W'(1);
      pend_q <= 1'b0;
    end else if (lim_wr_i) begin
      lim_q  <= lim_wdata_i;
      cnt_q  <= FIELD_W'(1);
      pend_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= step.cnt[FIELD_W-1:0];
      // a wrap in the acknowledge cycle wins over the acknowledge
      pend_q <= wrap_o | (pend_q & ~lim_rd_i);
    end
  end

  assign cnt_o  = cnt_q;
  assign lim_o  = lim_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/utmr_decode.sv
module utmr_decode
  import utmr_pkg::*;
#(
  parameter int NUM_T   = 5,
  parameter int PAGE_AW = 12,
  parameter int ADDR_W  = 15
) (
  input  logic                         sel_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [NUM_T-1:0]             lim_wr_o,
  output logic [NUM_T-1:0]             lim_rd_o,
  output logic                         rd_en_o,
  output logic [ADDR_W-PAGE_AW-1:0]    rd_idx_o,
  output reg_kind_e                    rd_kind_o
);
  localparam int PG_W = ADDR_W - PAGE_AW;

  logic [PG_W-1:0]      page;
  logic [PAGE_AW-3:0]   word;
  logic                 page_ok;
  reg_kind_e            kind;

  assign page    = addr_i[ADDR_W-1:PAGE_AW];
  assign word    = addr_i[PAGE_AW-1:2];
  assign page_ok = {1'b0, page} < (PG_W+1)'(NUM_T);

  always_comb begin
    kind = RK_NONE;
    if (addr_i[1:0] == 2'b00 && page_ok) begin
      if (word == '0)                      kind = RK_LIMIT;
      else if (word == (PAGE_AW-2)'(1))    kind = RK_COUNT;
    end
  end

  for (genvar j = 0; j < NUM_T; j++) begin : g_sel
    logic hit;
    assign hit         = sel_i && kind == RK_LIMIT && page == PG_W'(j);
    assign lim_wr_o[j] = hit & we_i;
    assign lim_rd_o[j] = hit & ~we_i;
  end

  assign rd_en_o   = sel_i & ~we_i;
  assign rd_idx_o  = page;
  assign rd_kind_o = kind;
endmodule

// File: rtl/utmr_rdmux.sv
module utmr_rdmux
  import utmr_pkg::*;
#(
  parameter int NUM_T   = 5,
  parameter int FIELD_W = 21,
  parameter int IDX_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en_i,
  input  logic [IDX_W-1:0]                rd_idx_i,
  input  reg_kind_e                       rd_kind_i,
  input  logic [NUM_T-1:0]                pend_i,
  input  logic [NUM_T-1:0][FIELD_W-1:0]   cnt_i,
  input  logic [NUM_T-1:0][FIELD_W-1:0]   lim_i,
  output logic [WORD_W-1:0]               rdata_o
);
  logic               sel_pend;
  logic [FIELD_W-1:0] sel_fld;
  logic [WORD_W-1:0]  rd_val;

  always_comb begin
    sel_pend = 1'b0;
    sel_fld  = '0;
    for (int j = 0; j < NUM_T; j++) begin
      if (rd_idx_i == IDX_W'(j)) begin
        sel_pend = pend_i[j];
        sel_fld  = (rd_kind_i == RK_LIMIT) ? lim_i[j] : cnt_i[j];
      end
    end
    rd_val = '0;
    if (rd_en_i && rd_kind_i != RK_NONE) rd_val = field_to_word(sel_pend, fld_t'(sel_fld));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_val;
  end
endmodule

// File: rtl/usec_timer_bank.sv
module usec_timer_bank
  import utmr_pkg::*;
#(
  parameter  int NUM_CPU = 4,
  parameter  int FIELD_W = 21,
  parameter  int PAGE_AW = 12,
  localparam int NUM_T   = NUM_CPU + 1,
  localparam int IDX_W   = $clog2(NUM_T),
  localparam int ADDR_W  = PAGE_AW + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               us_tick,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_sys_l10,
  output logic [NUM_CPU-1:0] irq_cpu_l14
);
  // named internal events for the checker
  logic [NUM_T-1:0]              t_lim_wr;
  logic [NUM_T-1:0]              t_lim_rd;
  logic [NUM_T-1:0]              t_wrap;
  logic [NUM_T-1:0]              t_pend;
  logic [NUM_T-1:0][FIELD_W-1:0] t_cnt;
  logic [NUM_T-1:0][FIELD_W-1:0] t_lim;

  logic             rd_en;
  logic [IDX_W-1:0] rd_idx;
  reg_kind_e        rd_kind;
  fld_t             wr_fld_full;
  logic [FIELD_W-1:0] wr_field;

  assign wr_fld_full = word_to_field(bus_wdata);
  assign wr_field    = wr_fld_full[FIELD_W-1:0];

  utmr_decode #(
    .NUM_T  (NUM_T),
    .PAGE_AW(PAGE_AW),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .sel_i    (bus_sel),
    .we_i     (bus_we),
    .addr_i   (bus_addr),
    .lim_wr_o (t_lim_wr),
    .lim_rd_o (t_lim_rd),
    .rd_en_o  (rd_en),
    .rd_idx_o (rd_idx),
    .rd_kind_o(rd_kind)
  );

  for (genvar j = 0; j < NUM_T; j++) begin : g_tmr
    utmr_core #(.FIELD_W(FIELD_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (us_tick),
      .lim_wr_i   (t_lim_wr[j]),
      .lim_wdata_i(wr_field),
      .lim_rd_i   (t_lim_rd[j]),
      .cnt_o      (t_cnt[j]),
      .lim_o      (t_lim[j]),
      .pend_o     (t_pend[j]),
      .wrap_o     (t_wrap[j])
    );
  end

  utmr_rdmux #(
    .NUM_T  (NUM_T),
    .FIELD_W(FIELD_W),
    .IDX_W  (IDX_W)
  ) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en_i  (rd_en),
    .rd_idx_i (rd_idx),
    .rd_kind_i(rd_kind),
    .pend_i   (t_pend),
    .cnt_i    (t_cnt),
    .lim_i    (t_lim),
    .rdata_o  (bus_rdata)
  );

  assign irq_sys_l10 = t_pend[NUM_CPU];
  assign irq_cpu_l14 = t_pend[NUM_CPU-1:0];
endmodule

// File: rtl/utmr_checker.sv
module utmr_checker #(
  parameter int NUM_T   = 5,
  parameter int FIELD_W = 21
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          us_tick,
  input logic                          bus_sel,
  input logic                          bus_we,
  input logic [31:0]                   bus_rdata,
  input logic [NUM_T-1:0]              t_lim_wr,
  input logic [NUM_T-1:0]              t_lim_rd,
  input logic [NUM_T-1:0]              t_wrap,
  input logic [NUM_T-1:0]              t_pend,
  input logic [NUM_T-1:0][FIELD_W-1:0] t_cnt,
  input logic [NUM_T-1:0][FIELD_W-1:0] t_lim
);
  p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(t_lim_wr) && $onehot0(t_lim_rd));

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> bus_rdata == 32'd0);

  for (genvar j = 0; j < NUM_T; j++) begin : g_chk
    p_wr_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      t_lim_wr[j] |=> !t_pend[j] && t_cnt[j] == FIELD_W'(1));

    p_wrap_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      t_wrap[j] && !t_lim_wr[j] |=> t_pend[j] && t_cnt[j] == FIELD_W'(1));

    p_rise_needs_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(t_pend[j]) |-> $past(t_wrap[j]));

    p_cnt_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      t_cnt[j] != '0);

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !us_tick && !t_lim_wr[j] |=> $stable(t_cnt[j]) && $stable(t_lim[j]));

    p_zero_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      t_lim[j] == '0 |-> !t_pend[j] && t_cnt[j] == FIELD_W'(1));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      t_lim_rd[j] && !t_wrap[j] && !t_lim_wr[j] |=> !t_pend[j]);
  end
endmodule

bind usec_timer_bank utmr_checker #(
  .NUM_T  (NUM_T),
  .FIELD_W(FIELD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .us_tick  (us_tick),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_rdata(bus_rdata),
  .t_lim_wr (t_lim_wr),
  .t_lim_rd (t_lim_rd),
  .t_wrap   (t_wrap),
  .t_pend   (t_pend),
  .t_cnt    (t_cnt),
  .t_lim    (t_lim)
);

// File: tb/usec_timer_bank_tb.sv
`timescale 1ns/1ps
module usec_timer_bank_tb;
  localparam int NCPU = 4;
  localparam int NT   = NCPU + 1;
  localparam int PAW  = 12;
  localparam int AW   = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          us_tick = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_sys_l10;
  logic [NCPU-1:0] irq_cpu_l14;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  usec_timer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_sys_l10(irq_sys_l10), .irq_cpu_l14(irq_cpu_l14)
  );

  function automatic logic [AW-1:0] addr_of(int pg, int off);
    return AW'((pg << PAW) + off);
  endfunction

  function automatic logic [31:0] ew(bit p, int f);
    return {p, 21'(f), 10'b0};
  endfunction

  function automatic logic [31:0] irqv();
    return {27'd0, irq_sys_l10, irq_cpu_l14};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int pg, int off, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = addr_of(pg, off); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(int pg, int off, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = addr_of(pg, off);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    us_tick = 1'b1;
    @(negedge clk);
    us_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int lims [4] = '{2, 3, 5, 7};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irqv(), 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    for (int j = 0; j < NT; j++) begin
      rd(j, 4, d); check("R1 count", d, ew(0, 1));
      rd(j, 0, d); check("R1 limit", d, 32'd0);
    end

    // R2 R3 R6 R7 R9 sweep over every timer and several limits
    for (int j = 0; j < NT; j++) begin
      foreach (lims[i]) begin
        int L, P;
        L = lims[i];
        P = L - 1;
        wr(j, 0, (L == 5) ? (32'h8000_03FF | 32'(L << 10)) : 32'(L << 10));
        rd(j, 4, d); check("R2 count after limit write", d, ew(0, 1));
        rd(j, 0, d); check("R2 limit readback", d, ew(0, L));
        for (int k = 1; k <= 2 * P + 1; k++) begin
          tick();
          rd(j, 4, d); check("R3/R7 count after ticks", d, ew(k >= P, 1 + (k % P)));
          check("R9 irq vector", irqv(), (k >= P) ? 32'(1 << j) : 32'd0);
        end
        repeat (10) @(negedge clk);
        rd(j, 4, d); check("R4 hold without tick", d, ew(1, 1 + ((2 * P + 1) % P)));
        rd(j, 0, d); check("R6 limit read returns flag", d, ew(1, L));
        check("R6 irq dropped", irqv(), 32'd0);
        rd(j, 0, d); check("R6 flag cleared", d, ew(0, L));
      end
      wr(j, 0, 32'd0);
    end

    // R5 zero limit parks the timer
    wr(1, 0, 32'(3 << 10));
    tick();
    wr(1, 0, 32'd0);
    for (int k = 0; k < 8; k++) tick();
    rd(1, 4, d); check("R5 zero limit count", d, ew(0, 1));
    check("R5 zero limit irq", irqv(), 32'd0);

    // R3 limit of one fires every tick
    wr(2, 0, 32'(1 << 10));
    tick();
    rd(2, 4, d); check("R3 limit one first tick", d, ew(1, 1));
    tick();
    rd(2, 0, d); check("R3 limit one limit read", d, ew(1, 1));
    tick();
    check("R3 limit one refires", irqv(), 32'(1 << 2));
    wr(2, 0, 32'd0);

    // R6 wrap and acknowledge in the same cycle
    wr(3, 0, 32'(3 << 10));
    tick();
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = addr_of(3, 0); us_tick = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; us_tick = 1'b0;
    check("R6 race returns old flag", bus_rdata, ew(0, 3));
    check("R6 race wrap wins", irqv(), 32'(1 << 3));
    rd(3, 0, d); check("R6 race later read", d, ew(1, 3));
    wr(3, 0, 32'd0);

    // R7 count writes ignored
    wr(0, 0, 32'(5 << 10));
    tick(); tick();
    wr(0, 4, 32'h0001_0400);
    rd(0, 4, d); check("R7 count write ignored", d, ew(0, 3));
    rd(0, 0, d); check("R7 limit untouched", d, ew(0, 5));
    wr(0, 0, 32'd0);

    // R8 unmapped space
    wr(5, 0, 32'(3 << 10));
    wr(7, 0, 32'(3 << 10));
    wr(0, 8, 32'(3 << 10));
    wr(0, 1, 32'(3 << 10));
    for (int j = 0; j < NT; j++) begin
      rd(j, 0, d); check("R8 unmapped write ignored", d, 32'd0);
    end
    for (int pg = 5; pg < 8; pg++) begin
      rd(pg, 0, d); check("R8 high page limit read", d, 32'd0);
      rd(pg, 4, d); check("R8 high page count read", d, 32'd0);
    end
    rd(0, 8, d); check("R8 unmapped offset", d, 32'd0);
    rd(0, 1, d); check("R8 misaligned", d, 32'd0);

    // R9 independent timers
    wr(0, 0, 32'(3 << 10));
    wr(4, 0, 32'(4 << 10));
    tick(); tick(); tick();
    check("R9 two timers pending", irqv(), 32'h11);
    rd(0, 4, d); check("R9 timer0 count", d, ew(1, 2));
    rd(4, 4, d); check("R9 system count", d, ew(1, 1));
    rd(0, 0, d);
    check("R9 ack one timer only", irqv(), 32'h10);

    // R10 read data returns to zero when idle
    @(negedge clk);
    check("R10 idle rdata", bus_rdata, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule